// File: doc/BRIEF.md
# Dual-Clock Latched Serial-to-Parallel Register

This block collects a serial bit stream into a shift stage that is clocked by its own strobe. A second strobe copies the whole shift stage, all bits at once, into a storage register, and the storage register drives the parallel outputs. The pins therefore change only when the storage strobe is given, however many bits have been shifted in since the last one. The last shift bit leaves the block as a cascade output, so several blocks can be chained into a longer register. A parameter also builds several 8-bit sections inside one instance.

The parallel outputs are meant to be tri-stated. Inside the block they appear as a data vector and a per-bit drive-enable vector, so the high-impedance buffer can sit at the pad level. An active-low clear empties the shift stage at once, without waiting for a clock. The clear does not reach the storage register, so the values on the pins hold through it. An active-low output enable controls the drive-enable vector and has no effect on the cascade output. A global active-low power-on reset puts both stages at zero.

Top module: `sipo_latch_reg`

## Requirements
- R1: On each rising edge of `shift_clk`, while `clr_n` and `por_n` are high, every shift bit i takes the old value of bit i-1, and bit 0 takes `sin`.
- R2: On each rising edge of `store_clk`, the storage register takes the whole shift stage as it stood just before that edge, and `pdata` shows the storage register.
- R3: While `clr_n` is low, the shift stage is zero at once without any clock edge, `cascade_out` is low, and `shift_clk` edges shift nothing in.
- R4: `clr_n` leaves the storage register and `pdata` unchanged until the next `store_clk` edge.
- R5: With `oe_n` high, every bit of `pdrive` is 0 (high impedance). With `oe_n` low, every bit of `pdrive` is 1 and the storage value is driven.
- R6: `cascade_out` always equals the highest shift bit, whatever the value of `oe_n`.
- R7: When `shift_clk` and `store_clk` rise together, the storage register takes the shift-stage value from before that edge, so it stays one shift behind.
- R8: While `por_n` is low, the shift stage and the storage register are both zero.
- R9: An instance with SECTIONS = N behaves like N chained single-section instances: shift bit 8k+7 feeds bit 8k+8, and `pdata[8k+7:8k]` is section k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Rising-edge strobe of the shift stage |
| store_clk | input | 1 | Rising-edge strobe of the storage register |
| por_n | input | 1 | Global power-on reset, active low, asynchronous |
| clr_n | input | 1 | Shift-stage clear, active low, asynchronous |
| oe_n | input | 1 | Parallel output enable, active low |
| sin | input | 1 | Serial data input |
| pdata | output | 8*SECTIONS | Storage register value |
| pdrive | output | 8*SECTIONS | Per-bit drive enable for the parallel pins |
| cascade_out | output | 1 | Last shift bit, for chaining |

## Verification
The bench builds two single-section instances, with the cascade output of the first wired to the serial input of the second, and one two-section instance that shares the same inputs. Comparing the two-section outputs against the chained pair shows the internal stitching between sections is right (R9). The chained pair also shows that bits cross a device boundary as expected. Random 16-bit words are shifted through, and the storage strobe is given at chosen points. Clear pulses arrive mid-stream between strobes, and in one case the two strobes rise in the same instant.

// File: rtl/sipo_latch_pkg.sv
package sipo_latch_pkg;
    localparam int SECTION_W = 8;

    function automatic int total_width(input int sections);
        return SECTION_W * sections;
    endfunction
endpackage

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         din,
    output logic [W-1:0] bits
);
    typedef struct packed {
        logic [W-1:0] sh;
    } shift_state_t;

    shift_state_t state_d, state_q;

    always_comb begin
        state_d    = state_q;
        state_d.sh = {state_q.sh[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bits = state_q.sh;
endmodule

// File: rtl/sipo_store_stage.sv
module sipo_store_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] load,
    output logic [W-1:0] bits
);
    typedef struct packed {
        logic [W-1:0] st;
    } store_state_t;

    store_state_t state_d, state_q;

    always_comb begin
        state_d    = state_q;
        state_d.st = load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bits = state_q.st;
endmodule

// File: rtl/sipo_out_drive.sv
module sipo_out_drive #(
    parameter int W = 8
) (
    input  logic         oe_n,
    input  logic [W-1:0] value,
    output logic [W-1:0] data,
    output logic [W-1:0] drive
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        assign data[i]  = value[i];
        assign drive[i] = ~oe_n;
    end
endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg
    import sipo_latch_pkg::*;
#(
    parameter int SECTIONS = 1
) (
    input  logic                            shift_clk,
    input  logic                            store_clk,
    input  logic                            por_n,
    input  logic                            clr_n,
    input  logic                            oe_n,
    input  logic                            sin,
    output logic [SECTION_W*SECTIONS-1:0]   pdata,
    output logic [SECTION_W*SECTIONS-1:0]   pdrive,
    output logic                            cascade_out
);
    localparam int W = total_width(SECTIONS);

    logic [W-1:0] sh_bits;
    logic [W-1:0] st_bits;
    logic         sh_rst_n;

    assign sh_rst_n = clr_n & por_n;

    sipo_shift_stage #(.W(W)) u_shift (
        .clk   (shift_clk),
        .rst_n (sh_rst_n),
        .din   (sin),
        .bits  (sh_bits)
    );

    sipo_store_stage #(.W(W)) u_store (
        .clk   (store_clk),
        .rst_n (por_n),
        .load  (sh_bits),
        .bits  (st_bits)
    );

    sipo_out_drive #(.W(W)) u_drive (
        .oe_n  (oe_n),
        .value (st_bits),
        .data  (pdata),
        .drive (pdrive)
    );

    assign cascade_out = sh_bits[W-1];
endmodule

// File: rtl/sipo_latch_chk.sv
module sipo_latch_chk #(
    parameter int W = 8
) (
    input logic         shift_clk,
    input logic         store_clk,
    input logic         por_n,
    input logic         clr_n,
    input logic         oe_n,
    input logic         sin,
    input logic [W-1:0] sh_bits,
    input logic [W-1:0] st_bits,
    input logic [W-1:0] pdata,
    input logic [W-1:0] pdrive,
    input logic         cascade_out
);
    logic       sh_seen, st_seen;
    logic [7:0] clr_cnt;

    always_ff @(posedge shift_clk or negedge por_n) begin
        if (!por_n) sh_seen <= 1'b0;
        else        sh_seen <= 1'b1;
    end

    always_ff @(posedge store_clk or negedge por_n) begin
        if (!por_n) st_seen <= 1'b0;
        else        st_seen <= 1'b1;
    end

    always_ff @(negedge clr_n or negedge por_n) begin
        if (!por_n) clr_cnt <= '0;
        else        clr_cnt <= clr_cnt + 8'd1;
    end

    // R1: one-place shift with serial input at bit 0 when no clear intervened
    a_r1_shift_step: assert property (@(posedge shift_clk) disable iff (!por_n || !clr_n)
        sh_seen && $past(clr_n) && $stable(clr_cnt)
            |-> sh_bits == {$past(sh_bits[W-2:0]), $past(sin)});

    // R2: storage holds the shift stage sampled at the previous storage edge
    a_r2_store_copy: assert property (@(posedge store_clk) disable iff (!por_n)
        st_seen |-> st_bits == $past(sh_bits));

    // R3: clear forces shift stage and cascade output low
    a_r3_clear_zero: assert property (@(posedge shift_clk) disable iff (!por_n)
        !clr_n |-> (sh_bits == '0) && !cascade_out);

    // R5: output enable controls all drive bits together
    a_r5_drive_off: assert property (@(posedge shift_clk) disable iff (!por_n)
        oe_n |-> pdrive == '0);
    a_r5_drive_on: assert property (@(posedge shift_clk) disable iff (!por_n)
        !oe_n |-> (pdrive == '1) && (pdata == st_bits));
endmodule

bind sipo_latch_reg sipo_latch_chk #(.W(W)) u_chk (
    .shift_clk   (shift_clk),
    .store_clk   (store_clk),
    .por_n       (por_n),
    .clr_n       (clr_n),
    .oe_n        (oe_n),
    .sin         (sin),
    .sh_bits     (sh_bits),
    .st_bits     (st_bits),
    .pdata       (pdata),
    .pdrive      (pdrive),
    .cascade_out (cascade_out)
);

// File: tb/sipo_latch_reg_tb.sv
module sipo_latch_reg_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic shift_clk = 1'b0, store_clk = 1'b0;
    logic por_n = 1'b0, clr_n = 1'b1, oe_n = 1'b1, sin = 1'b0;

    logic [7:0]  a_data, a_drv, b_data, b_drv;
    logic [15:0] w_data, w_drv;
    logic        a_cas, b_cas, w_cas;

    int checks = 0;
    int errors = 0;

    logic [15:0] exp_sh = '0;
    logic [15:0] exp_st = '0;
    logic [15:0] exp_q[$];
    event        ev_store;
    int          cycles = 0;

    sipo_latch_reg #(.SECTIONS(1)) u_dut (
        .shift_clk(shift_clk), .store_clk(store_clk), .por_n(por_n), .clr_n(clr_n),
        .oe_n(oe_n), .sin(sin), .pdata(a_data), .pdrive(a_drv), .cascade_out(a_cas));

    sipo_latch_reg #(.SECTIONS(1)) u_next (
        .shift_clk(shift_clk), .store_clk(store_clk), .por_n(por_n), .clr_n(clr_n),
        .oe_n(oe_n), .sin(a_cas), .pdata(b_data), .pdrive(b_drv), .cascade_out(b_cas));

    sipo_latch_reg #(.SECTIONS(2)) u_wide (
        .shift_clk(shift_clk), .store_clk(store_clk), .por_n(por_n), .clr_n(clr_n),
        .oe_n(oe_n), .sin(sin), .pdata(w_data), .pdrive(w_drv), .cascade_out(w_cas));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        sin = b;
        #2 shift_clk = 1'b1;
        if (clr_n) exp_sh = {exp_sh[14:0], b};
        #3 shift_clk = 1'b0;
        #5;
    endtask

    task automatic store_pulse();
        #2 store_clk = 1'b1;
        exp_st = exp_sh;
        exp_q.push_back(exp_st);
        -> ev_store;
        #3 store_clk = 1'b0;
        #5;
    endtask

    task automatic clear_pulse();
        #2 clr_n = 1'b0;
        exp_sh = '0;
        #1 check("R3 cascade low during clear", {14'd0, b_cas, w_cas}, 16'd0);
        #2 clr_n = 1'b1;
        #5;
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            logic [15:0] e;
            @(ev_store);
            #1;
            e = exp_q.pop_front();
            check("R2 chained pair storage", {b_data, a_data}, e);
            check("R9 wide instance storage", w_data, e);
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below 200000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] word;
        // R8: power-on reset
        #7;
        check("R8 reset storage", {b_data, a_data}, 16'd0);
        check("R8 reset cascade", {15'd0, b_cas}, 16'd0);
        check("R5 drive off while oe_n high", w_drv, 16'd0);
        shift_bit(1'b1);
        check("R8 shift held in reset", {15'd0, a_cas}, 16'd0);
        #3 por_n = 1'b1;
        exp_sh = '0;
        #5;

        // R1, R2, R9: random words, storage strobe after each
        for (int n = 0; n < 6; n++) begin
            word = 16'($urandom);
            for (int i = 15; i >= 0; i--) shift_bit(word[i]);
            check("R1 cascade tracks top bit", {15'd0, w_cas}, {15'd0, exp_sh[15]});
            store_pulse();
        end
        check("R1 last word shifted in order", exp_st, word);

        // R6: cascade unaffected by oe_n
        oe_n = 1'b1;
        shift_bit(1'b1);
        check("R6 cascade with oe_n high", {14'd0, b_cas, w_cas}, {14'd0, exp_sh[15], exp_sh[15]});
        check("R5 drive off", {b_drv, a_drv}, 16'd0);
        oe_n = 1'b0;
        #1 check("R5 drive on", {b_drv, a_drv}, 16'hFFFF);
        check("R5 data driven", w_data, exp_st);

        // R3, R4: mid-stream clear keeps latched outputs
        for (int i = 0; i < 5; i++) shift_bit(1'b1);
        clear_pulse();
        check("R4 storage kept through clear", {b_data, a_data}, exp_st);
        clr_n = 1'b0; exp_sh = '0;
        shift_bit(1'b1);
        shift_bit(1'b1);
        clr_n = 1'b1;
        #5;
        check("R4 storage kept while clear held", w_data, exp_st);
        store_pulse();
        check("R3 shift stage emptied and held", exp_st, 16'd0);

        // R7: tied strobes
        for (int i = 0; i < 16; i++) shift_bit(i[0]);
        sin = 1'b1;
        #2 begin shift_clk = 1'b1; store_clk = 1'b1; end
        exp_st = exp_sh;
        exp_sh = {exp_sh[14:0], 1'b1};
        #3 begin shift_clk = 1'b0; store_clk = 1'b0; end
        #1 check("R7 tied strobes store old value", {b_data, a_data}, exp_st);
        check("R7 wide tied strobes", w_data, exp_st);
        #4 store_pulse();

        #20;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule